// File: doc/BRIEF.md
# SAR Converter Conversion Sequencer

This block is the digital control half of a 12-bit successive-approximation converter. It uses its own data clock to ship results out. A host pulls a read/convert line low, with an active-low select also low, to begin a conversion. The block then drops an active-low busy flag for a fixed number of system clocks. At the end of that window it captures the 12-bit word that the analog core presents on a parallel port. The same start command also launches a serial transfer of the result captured by the previous conversion. That transfer runs on a data clock the block generates itself and gives exactly twelve pulses.

Before each transfer the stored word can be recoded. It is sent either as straight binary or as two's complement, where the top bit is inverted. A power-down input stops new conversions and leaves the stored result untouched. Between transfers the serial data line rests at the level the tag input had when the current conversion began. All control inputs arrive asynchronously and each passes through two flops before any edge is detected.

Top module: `sar_conv_seq`

## Requirements
- R1: With the select low, a falling edge of read/convert starts a conversion: busy_n_o reads low 3 clock cycles after the input changes (two synchronizer flops plus one state register). After release, no further conversion follows the finished one.
- R2: With read/convert low, a falling edge of the select starts a conversion with the same 3-cycle latency, because the two lines are ORed before edge detection.
- R3: busy_n_o stays low for exactly CONV_CYC cycles. The core word is captured on the clock edge where busy_n_o returns high.
- R4: If select and read/convert are both low when busy_n_o returns high, busy_n_o is high for exactly one cycle and a new conversion starts. Its transfer carries the word that was just captured.
- R5: Every start sends the previously captured word, MSB first. Bit k (k=0 for the MSB) is placed on sdata_o at the start edge plus 4*PHASE_CYC*k cycles. sclk_o rises PHASE_CYC cycles into each bit and falls 3*PHASE_CYC cycles into it, giving exactly 12 rising edges per transfer.
- R6: sclk_o is low whenever no transfer is running. sdata_o changes only in a cycle where sclk_o is low and was low in the cycle before, so data is stable across both clock edges.
- R7: When a transfer ends, sdata_o holds the tag level sampled at that conversion's start. Later tag changes have no effect on sdata_o until the next start.
- R8: With fmt_sb_i high (sampled at start) the word is sent unchanged. With it low, bit 11 is inverted, so a core word of 800h is sent as 000h.
- R9: While pwrdn_i is high no conversion starts, busy_n_o stays high and the captured word is kept. The next conversion after power-down sends that kept word.
- R10: Falling edges of the control inputs while busy_n_o is low are ignored. If the inputs are high again when the conversion ends, no extra conversion follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n_i | input | 1 | Active-low select, asynchronous |
| rdconv_i | input | 1 | Read/convert line, a falling edge starts a conversion, asynchronous |
| pwrdn_i | input | 1 | Power-down, high blocks conversions |
| fmt_sb_i | input | 1 | High selects straight binary, low selects two's complement |
| tag_i | input | 1 | Level parked on the data line between transfers |
| core_res_i | input | RES_W | Result word from the analog core |
| busy_n_o | output | 1 | Low while a conversion runs |
| sclk_o | output | 1 | Self-generated serial data clock |
| sdata_o | output | 1 | Serial data, MSB first |

## Verification
All results are timed from S, the clock edge that starts a conversion. S is the third rising edge after the control input changes. busy_n_o is low from S, returns high at S+CONV_CYC, and in the restart case falls again at S+CONV_CYC+1. Bit k is checked in mid-high of its clock pulse, at S+4*PHASE_CYC*k+2*PHASE_CYC. The parked tag is checked at S+48*PHASE_CYC. The bench drives inputs and samples outputs on falling clock edges, waits exactly those edge counts and compares with words it recodes itself from the previous core value.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int NSYNC  = 5;
  localparam int SI_SEL = 4;
  localparam int SI_RC  = 3;
  localparam int SI_PD  = 2;
  localparam int SI_FMT = 1;
  localparam int SI_TAG = 0;
  localparam logic [NSYNC-1:0] SYNC_RST = 5'b11000;

  typedef enum logic [1:0] {
    SLOT_LEAD  = 2'd0,
    SLOT_HI_A  = 2'd1,
    SLOT_HI_B  = 2'd2,
    SLOT_TRAIL = 2'd3
  } slot_e;
endpackage

// File: rtl/sar_sync2.sv
module sar_sync2 #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic meta_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= RST_VAL[b];
        q_o[b] <= RST_VAL[b];
      end else begin
        meta_q <= d_i[b];
        q_o[b] <= meta_q;
      end
    end
  end
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int RES_W    = 12,
  parameter int CONV_CYC = 2000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_n_s,
  input  logic             pwrdn_s,
  input  logic [RES_W-1:0] core_res_i,
  output logic             busy_n_o,
  output logic             start_o,
  output logic [RES_W-1:0] res_o
);
  localparam int CW = (CONV_CYC > 1) ? $clog2(CONV_CYC) : 1;

  logic          req_q;
  logic          ended_q;
  logic [CW-1:0] cnt_q;
  logic          last_c;

  assign last_c  = (cnt_q == CW'(CONV_CYC - 1));
  // a fresh falling edge, or the line still low as the previous conversion closes
  assign start_o = busy_n_o & ~pwrdn_s & ~req_n_s & (req_q | ended_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_n_o <= 1'b1;
      cnt_q    <= '0;
      res_o    <= '0;
      req_q    <= 1'b1;
      ended_q  <= 1'b0;
    end else begin
      req_q   <= req_n_s;
      ended_q <= ~busy_n_o & last_c;
      if (busy_n_o) begin
        if (start_o) begin
          busy_n_o <= 1'b0;
          cnt_q    <= '0;
        end
      end else if (last_c) begin
        busy_n_o <= 1'b1;
        res_o    <= core_res_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_n_o) |-> ($past(cnt_q) == CW'(CONV_CYC - 1))); // R3
  AST_RES_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_n_o) |-> (res_o == $past(core_res_i))); // R3
  AST_PD_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (busy_n_o && pwrdn_s) |=> busy_n_o); // R9
  AST_RES_KEEP: assert property (@(posedge clk) disable iff (rst)
    (busy_n_o && $past(busy_n_o)) |-> $stable(res_o)); // R9
endmodule

// File: rtl/sar_ser_tx.sv
module sar_ser_tx
  import sar_seq_pkg::*;
#(
  parameter int RES_W     = 12,
  parameter int PHASE_CYC = 27
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [RES_W-1:0] word_i,
  input  logic             fmt_sb_i,
  input  logic             tag_i,
  output logic             sclk_o,
  output logic             sdata_o
);
  localparam int PW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam int BW = $clog2(RES_W);

  logic             active_q;
  logic             tag_q;
  logic [RES_W-1:0] sh_q;
  logic [PW-1:0]    ph_q;
  logic [BW-1:0]    bit_q;
  slot_e            slot_q;
  logic [RES_W-1:0] word_fmt;

  assign word_fmt = fmt_sb_i ? word_i : {~word_i[RES_W-1], word_i[RES_W-2:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      tag_q    <= 1'b0;
      sh_q     <= '0;
      ph_q     <= '0;
      bit_q    <= '0;
      slot_q   <= SLOT_LEAD;
      sclk_o   <= 1'b0;
      sdata_o  <= 1'b0;
    end else if (start_i) begin
      active_q <= 1'b1;
      tag_q    <= tag_i;
      sh_q     <= word_fmt;
      sdata_o  <= word_fmt[RES_W-1];
      sclk_o   <= 1'b0;
      ph_q     <= '0;
      bit_q    <= '0;
      slot_q   <= SLOT_LEAD;
    end else if (active_q) begin
      if (ph_q == PW'(PHASE_CYC - 1)) begin
        ph_q <= '0;
        unique case (slot_q)
          SLOT_LEAD: begin
            slot_q <= SLOT_HI_A;
            sclk_o <= 1'b1;
          end
          SLOT_HI_A: slot_q <= SLOT_HI_B;
          SLOT_HI_B: begin
            slot_q <= SLOT_TRAIL;
            sclk_o <= 1'b0;
          end
          SLOT_TRAIL: begin
            slot_q <= SLOT_LEAD;
            if (bit_q == BW'(RES_W - 1)) begin
              active_q <= 1'b0;
              sdata_o  <= tag_q;
            end else begin
              bit_q   <= bit_q + 1'b1;
              sh_q    <= {sh_q[RES_W-2:0], 1'b0};
              sdata_o <= sh_q[RES_W-2];
            end
          end
          default: slot_q <= SLOT_LEAD;
        endcase
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  AST_EDGE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdata_o) |-> (!sclk_o && !$past(sclk_o))); // R6
  AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
    !active_q |-> !sclk_o); // R6
  AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
    start_i |-> !active_q); // R5
  AST_TAG_PARK: assert property (@(posedge clk) disable iff (rst)
    (!active_q && $past(!active_q)) |-> $stable(sdata_o)); // R7
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_seq_pkg::*;
#(
  parameter int RES_W     = 12,
  parameter int CONV_CYC  = 2000,
  parameter int PHASE_CYC = 27
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_n_i,
  input  logic             rdconv_i,
  input  logic             pwrdn_i,
  input  logic             fmt_sb_i,
  input  logic             tag_i,
  input  logic [RES_W-1:0] core_res_i,
  output logic             busy_n_o,
  output logic             sclk_o,
  output logic             sdata_o
);
  logic [NSYNC-1:0] raw_in;
  logic [NSYNC-1:0] syn;
  logic             start;
  logic [RES_W-1:0] res;

  assign raw_in = {sel_n_i, rdconv_i, pwrdn_i, fmt_sb_i, tag_i};

  sar_sync2 #(.W(NSYNC), .RST_VAL(SYNC_RST)) i_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw_in),
    .q_o (syn)
  );

  sar_conv_ctrl #(.RES_W(RES_W), .CONV_CYC(CONV_CYC)) i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .req_n_s    (syn[SI_SEL] | syn[SI_RC]),
    .pwrdn_s    (syn[SI_PD]),
    .core_res_i (core_res_i),
    .busy_n_o   (busy_n_o),
    .start_o    (start),
    .res_o      (res)
  );

  sar_ser_tx #(.RES_W(RES_W), .PHASE_CYC(PHASE_CYC)) i_tx (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start),
    .word_i   (res),
    .fmt_sb_i (syn[SI_FMT]),
    .tag_i    (syn[SI_TAG]),
    .sclk_o   (sclk_o),
    .sdata_o  (sdata_o)
  );
endmodule

// File: tb/test_sar_conv_seq.sv
module test_sar_conv_seq;
  localparam int RW   = 12;
  localparam int CONV = 120;
  localparam int PH   = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_n = 1'b1, rdconv = 1'b1, pwrdn = 1'b0, fmt_sb = 1'b0, tag = 1'b0;
  logic [RW-1:0] core = '0;
  logic busy_n, sclk, sdata;

  int vectors = 0;
  int fails   = 0;
  int pulses  = 0;
  logic sclk_d = 1'b0;
  logic [RW-1:0] prev_raw = '0;
  logic park_exp = 1'b0;

  always #2 clk = ~clk;

  sar_conv_seq #(.RES_W(RW), .CONV_CYC(CONV), .PHASE_CYC(PH)) i_sar_conv_seq (
    .clk (clk), .rst (rst), .sel_n_i (sel_n), .rdconv_i (rdconv), .pwrdn_i (pwrdn),
    .fmt_sb_i (fmt_sb), .tag_i (tag), .core_res_i (core),
    .busy_n_o (busy_n), .sclk_o (sclk), .sdata_o (sdata)
  );

  always @(posedge clk) begin
    if (sclk && !sclk_d) pulses++;
    sclk_d = sclk;
  end

  function automatic logic [RW-1:0] fmtw(logic [RW-1:0] r, logic sb);
    return sb ? r : {~r[RW-1], r[RW-2:0]};
  endfunction

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_req(bit use_cs, logic v);
    if (use_cs) sel_n = v; else rdconv = v;
  endtask

  task automatic do_conv(logic [RW-1:0] raw, logic tg, logic sb, bit use_cs, bit keep_low, bit glitch);
    logic [RW-1:0] exp;
    logic [RW-1:0] exp2;
    int p0;
    if (use_cs) begin rdconv = 1'b0; sel_n = 1'b1; end
    else begin sel_n = 1'b0; rdconv = 1'b1; end
    core = raw; tag = tg; fmt_sb = sb;
    cyc(4);
    chk(sclk == 1'b0, "R6 idle clock low", sclk, 0);
    chk(sdata == park_exp, "R7 parked level before start", sdata, park_exp);
    exp = fmtw(prev_raw, sb);
    p0 = pulses;
    drive_req(use_cs, 1'b0);
    cyc(3);
    chk(busy_n == 1'b0, use_cs ? "R2 select edge start" : "R1 read/convert edge start", busy_n, 0);
    chk(sdata == exp[RW-1], "R5 R8 msb at start", sdata, exp[RW-1]);
    if (!keep_low) drive_req(use_cs, 1'b1);
    for (int k = 0; k < RW; k++) begin
      cyc(k == 0 ? 2*PH : 4*PH);
      chk(sclk == 1'b1 && sdata == exp[RW-1-k], "R5 R8 serial bit", {sclk, sdata}, {1'b1, exp[RW-1-k]});
    end
    cyc(2*PH);
    chk(sdata == tg && sclk == 1'b0, "R7 tag parked after transfer", {sclk, sdata}, {1'b0, tg});
    chk(pulses - p0 == RW, "R5 clock pulse count", pulses - p0, RW);
    tag = ~tg;
    if (glitch) begin
      drive_req(use_cs, 1'b1); cyc(3);
      drive_req(use_cs, 1'b0); cyc(3);
      drive_req(use_cs, 1'b1);
      cyc(CONV - 1 - 48*PH - 6);
    end else begin
      cyc(CONV - 1 - 48*PH);
    end
    chk(busy_n == 1'b0, "R3 busy span", busy_n, 0);
    chk(sdata == tg, "R7 tag change ignored", sdata, tg);
    cyc(1);
    chk(busy_n == 1'b1, "R3 busy end", busy_n, 1);
    prev_raw = raw;
    park_exp = tg;
    if (keep_low) begin
      exp2 = fmtw(raw, sb);
      cyc(1);
      chk(busy_n == 1'b0, "R4 immediate restart", busy_n, 0);
      chk(sdata == exp2[RW-1], "R4 restart sends fresh word", sdata, exp2[RW-1]);
      drive_req(use_cs, 1'b1);
      cyc(CONV - 1);
      chk(busy_n == 1'b0, "R3 R4 restart span", busy_n, 0);
      cyc(1);
      chk(busy_n == 1'b1, "R3 R4 restart end", busy_n, 1);
      park_exp = ~tg;
    end else begin
      cyc(1);
      chk(busy_n == 1'b1, glitch ? "R10 edge during busy ignored" : "R1 no extra conversion", busy_n, 1);
    end
  endtask

  task automatic pd_try();
    sel_n = 1'b0; rdconv = 1'b1; pwrdn = 1'b1;
    cyc(4);
    rdconv = 1'b0;
    cyc(6);
    chk(busy_n == 1'b1, "R9 power-down blocks start", busy_n, 1);
    chk(sclk == 1'b0 && sdata == park_exp, "R9 no transfer in power-down", {sclk, sdata}, {1'b0, park_exp});
    rdconv = 1'b1;
    cyc(3);
    pwrdn = 1'b0;
    cyc(3);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd7741);
    cyc(5);
    rst = 1'b0;
    cyc(1);
    chk(busy_n == 1'b1 && sclk == 1'b0 && sdata == 1'b0, "R1 R6 reset idle", {busy_n, sclk, sdata}, 3'b100);

    do_conv(12'h800, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    do_conv(12'h800, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    do_conv(12'hFFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    do_conv(12'h000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    pd_try();
    do_conv(12'h5A5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    do_conv(12'h3C3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);

    for (int i = 0; i < 30; i++) begin
      logic [RW-1:0] r;
      bit kl, gl;
      r  = RW'($urandom);
      kl = ($urandom % 5) == 0;
      gl = !kl && (($urandom % 4) == 0);
      if (($urandom % 6) == 0) pd_try();
      do_conv(r, 1'($urandom), 1'($urandom), 1'($urandom), kl, gl);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule